// File: doc/BRIEF.md
# Push-Button Power Sequencing Controller

This block is the digital control core of a power-management device. It decides when the two supply rails of a system are switched on. Three sources can request power: a valid-input-supply flag, an active-low push-button, and an active-high software hold line driven by the processor. Power stays on only while at least one of these sources is present. When a button press starts the system, the block holds the processor in reset for a fixed 260 ms window. It then releases the reset line to high impedance. The processor must raise the hold line before the user lets go of the button.

The same button is also the user's way of asking for shutdown. Every press pulls the interrupt line low, and the line stays low until the processor clears it. Shutdown is driven by software: the processor finishes its own power-down work and drops the hold line last. When no source remains, the rails go off and the block returns to idle with the reset line driven low.

The button and hold inputs come from outside the clock domain, and each passes through a two-flop synchronizer. The supply flag and the clear strobe are taken as already synchronous to `clk`. The design has no data stream, so every pin is a plain level or strobe, with no valid/ready handshake.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Both rail enables go high when `supply_ok` is 1, or `btn_n` is 0, or `hold` is 1. A change on `supply_ok` reaches the rails after the next rising edge. A change on `btn_n` or `hold` reaches the rails after the third rising edge.
- R2: When a start is caused by the button (synchronized `btn_n` low while idle), `cpu_rst_oe` is 1 and `cpu_rst_n` is 0 for exactly `RST_CYC` cycles. After that, `cpu_rst_oe` becomes 0 (high impedance) and `cpu_rst_n` reads 1. `RST_CYC` is `RST_CYC_OVR` when that is nonzero, and `(CLK_HZ/1000)*RST_MS` otherwise.
- R3: A start caused only by `supply_ok` or `hold`, with no button press, releases the reset (`cpu_rst_oe` = 0) in the same cycle that the rails come up.
- R4: A new button press while the reset window is running does not restart it. A press while running does not pulse reset again.
- R5: When no enable source remains, both rails turn off on the same edge. The reset line is then driven low (`cpu_rst_oe` = 1, `cpu_rst_n` = 0).
- R6: `irq_n` goes low in the same cycle that the synchronized button is seen low. It then stays low until `irq_clr` is 1 while the synchronized button is high. A clear that arrives while the button is still low has no effect.
- R7: If `hold` is set before the button is released, the rails stay on after the release. Without `hold`, releasing the button turns the rails off.
- R8: During and right after reset, the rails are 0, `cpu_rst_oe` is 1, `cpu_rst_n` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Valid input supply present (synchronous) |
| btn_n | input | 1 | Push-button, active low (asynchronous) |
| hold | input | 1 | Software hold request, active high (asynchronous) |
| irq_clr | input | 1 | One-cycle strobe that clears the latched interrupt |
| rail1_en | output | 1 | Enable for the first supply rail |
| rail2_en | output | 1 | Enable for the second supply rail |
| cpu_rst_n | output | 1 | Value driven on the processor reset line |
| cpu_rst_oe | output | 1 | Reset line driver enable; 0 means high impedance |
| irq_n | output | 1 | Latched shutdown-request interrupt, active low |

## Verification
Two events can fall in the same cycle. The first is the end of the reset window. The second is a change on the button, either a re-press or a release that leaves only `hold` to keep power. The bench places a button toggle inside the window and checks that the release still lands on the exact cycle counted from the first press. A second case is an interrupt clear that arrives while the button is still low: the set must win, so `irq_n` stays low. Random phases toggle all sources at different rates so that clears, drop-outs and restarts overlap. A cycle-level reference built from the requirements judges every output on every cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_IDLE    = 2'd0,
    PS_RSTHOLD = 2'd1,
    PS_RUN     = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/pwr_sync2.sv
module pwr_sync2 #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= INIT[i];
        stab <= INIT[i];
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
  parameter int unsigned CNT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned W = (CNT > 1) ? $clog2(CNT) : 1;
  localparam logic [W-1:0] LAST = W'(CNT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/pwr_irq_latch.sv
module pwr_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic irq_n
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend <= 1'b0;
    else if (req)   pend <= 1'b1;
    else if (clr)   pend <= 1'b0;
  end

  assign irq_n = ~pend;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned RST_MS      = 260,
  parameter int unsigned RST_CYC_OVR = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic btn_n,
  input  logic hold,
  input  logic irq_clr,
  output logic rail1_en,
  output logic rail2_en,
  output logic cpu_rst_n,
  output logic cpu_rst_oe,
  output logic irq_n
);
  localparam int unsigned RST_CYC =
    (RST_CYC_OVR != 0) ? RST_CYC_OVR : (CLK_HZ / 1000) * RST_MS;

  logic [1:0] sync_q;
  logic       btn_s_n, hold_s;
  logic       any_src, tmr_done;
  pwr_state_t state, state_nx;

  pwr_sync2 #(.W(2), .INIT(2'b01)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({hold, btn_n}),
    .q    (sync_q)
  );
  assign btn_s_n = sync_q[0];
  assign hold_s  = sync_q[1];

  assign any_src = supply_ok | ~btn_s_n | hold_s;

  pwr_rst_timer #(.CNT(RST_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state == PS_RSTHOLD),
    .done (tmr_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      PS_IDLE: begin
        if (any_src) state_nx = (!btn_s_n) ? PS_RSTHOLD : PS_RUN;
      end
      PS_RSTHOLD: begin
        if (!any_src)     state_nx = PS_IDLE;
        else if (tmr_done) state_nx = PS_RUN;
      end
      PS_RUN: begin
        if (!any_src) state_nx = PS_IDLE;
      end
      default: state_nx = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_IDLE;
    else        state <= state_nx;
  end

  pwr_irq_latch u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (~btn_s_n),
    .clr  (irq_clr),
    .irq_n(irq_n)
  );

  assign rail1_en   = (state != PS_IDLE);
  assign rail2_en   = (state != PS_IDLE);
  assign cpu_rst_oe = (state != PS_RUN);
  assign cpu_rst_n  = (state == PS_RUN);
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int unsigned RST_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic irq_clr,
  input logic rail1_en,
  input logic rail2_en,
  input logic cpu_rst_n,
  input logic cpu_rst_oe,
  input logic irq_n
);
  int unsigned win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      win <= 0;
    else if (rail1_en && cpu_rst_oe) win <= win + 1;
    else                             win <= 0;
  end

  // R5: both rails switch together
  a_r5_rails_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rail1_en == rail2_en);

  // R5: unpowered means reset driven low
  a_r5_idle_rst_low: assert property (@(posedge clk) disable iff (!rst_n)
    !rail1_en |-> (cpu_rst_oe && !cpu_rst_n));

  // R2: reset window never exceeds its length
  a_r2_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    win <= RST_CYC);

  // R4: reset is released only while powered
  a_r4_release_powered: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst_oe) |-> rail1_en);

  // R6: pending interrupt holds without a clear
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !irq_clr) |=> !irq_n);
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_clr   (irq_clr),
  .rail1_en  (rail1_en),
  .rail2_en  (rail2_en),
  .cpu_rst_n (cpu_rst_n),
  .cpu_rst_oe(cpu_rst_oe),
  .irq_n     (irq_n)
);

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
  localparam int unsigned RC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, btn_n = 1'b1, hold = 1'b0, irq_clr = 1'b0;
  logic rail1_en, rail2_en, cpu_rst_n, cpu_rst_oe, irq_n;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_seq_ctrl #(.CLK_HZ(250_000_000), .RST_CYC_OVR(RC)) u_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .btn_n(btn_n),
    .hold(hold), .irq_clr(irq_clr), .rail1_en(rail1_en), .rail2_en(rail2_en),
    .cpu_rst_n(cpu_rst_n), .cpu_rst_oe(cpu_rst_oe), .irq_n(irq_n)
  );

  // reference built from the requirements: 0 idle, 1 reset window, 2 running
  logic b1, b2, h1, h2, m_irq;
  int   m_st, m_cnt;

  function automatic int next_state(int st, int cnt, bit src, bit bs_n);
    if (st == 0) return src ? (bs_n ? 2 : 1) : 0;
    if (!src) return 0;
    if (st == 1 && cnt == RC - 1) return 2;
    return st;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1 <= 1; b2 <= 1; h1 <= 0; h2 <= 0; m_irq <= 0; m_st <= 0; m_cnt <= 0;
    end else begin
      b1 <= btn_n; b2 <= b1; h1 <= hold; h2 <= h1;
      m_st  <= next_state(m_st, m_cnt, supply_ok | ~b2 | h2, b2);
      m_cnt <= (m_st == 1) ? m_cnt + 1 : 0;
      if (!b2) m_irq <= 1; else if (irq_clr) m_irq <= 0;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "rail1_en model", rail1_en, m_st != 0);
      chk("R5", "rail2_en model", rail2_en, m_st != 0);
      chk("R2", "cpu_rst_oe model", cpu_rst_oe, m_st != 2);
      chk("R3", "cpu_rst_n model", cpu_rst_n, m_st == 2);
      chk("R6", "irq_n model", irq_n, ~m_irq);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    step(3);
    chk("R8", "reset rails", rail1_en, 1'b0);
    chk("R8", "reset oe", cpu_rst_oe, 1'b1);
    chk("R8", "reset rst_n", cpu_rst_n, 1'b0);
    chk("R8", "reset irq_n", irq_n, 1'b1);
    rst_n = 1'b1;
    step(2);
    chk("R8", "after reset rails", rail1_en, 1'b0);

    // R2 / R4: button start, re-press inside the window
    btn_n = 1'b0;
    step(2);
    chk("R1", "rails before sync", rail1_en, 1'b0);
    step(1);
    chk("R1", "rails after 3 edges", rail1_en, 1'b1);
    chk("R2", "reset held", cpu_rst_oe, 1'b1);
    chk("R6", "irq on press", irq_n, 1'b0);
    hold = 1'b1;
    step(4);
    btn_n = 1'b1; step(2); btn_n = 1'b0;
    step(RC - 1 - 6);
    chk("R4", "still in window", cpu_rst_oe, 1'b1);
    step(1);
    chk("R4", "released on time", cpu_rst_oe, 1'b0);
    chk("R2", "released high", cpu_rst_n, 1'b1);

    // R7: hold keeps power past release
    btn_n = 1'b1;
    step(6);
    chk("R7", "hold keeps rails", rail1_en, 1'b1);
    chk("R6", "irq latched after release", irq_n, 1'b0);
    hold = 1'b0;
    step(2);
    chk("R5", "rails before hold sync", rail1_en, 1'b1);
    step(1);
    chk("R5", "rails off", rail1_en, 1'b0);
    chk("R5", "reset driven low", cpu_rst_oe, 1'b1);

    // R6: clear accepted when released, ignored while pressed
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    chk("R6", "cleared", irq_n, 1'b1);
    btn_n = 1'b0; step(3);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    chk("R6", "clear ignored while pressed", irq_n, 1'b0);
    btn_n = 1'b1; step(3);
    chk("R7", "no hold drops", rail1_en, 1'b0);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;

    // R3: non-button starts release reset at once
    supply_ok = 1'b1; step(1);
    chk("R1", "supply one edge", rail1_en, 1'b1);
    chk("R3", "supply start no reset", cpu_rst_oe, 1'b0);
    supply_ok = 1'b0; step(1);
    chk("R5", "supply gone", rail1_en, 1'b0);
    hold = 1'b1; step(3);
    chk("R3", "hold start rails", rail1_en, 1'b1);
    chk("R3", "hold start no reset", cpu_rst_oe, 1'b0);
    btn_n = 1'b0; step(4);
    chk("R4", "press while running no reset", cpu_rst_oe, 1'b0);
    btn_n = 1'b1; hold = 1'b0; step(4);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 40 == 0)  btn_n = ~btn_n;
      if ($urandom % 60 == 0)  hold = ~hold;
      if ($urandom % 150 == 0) supply_ok = ~supply_ok;
      irq_clr = ($urandom % 8 == 0);
      step(1);
    end
    summary();
  end
endmodule